// File: doc/BRIEF.md
# Serial Word Timer with Two-Rank Instruction Staging

This block paces a bit-serial processor. A position counter steps through the nine bit times of a word, 1 to 9, one per clock. It raises a word-marker strobe during the ninth position, which is the spacer slot. While one instruction executes from the upper rank of a two-rank instruction register, the next instruction arrives one bit per clock, least significant first, and is collected in the lower rank. The ninth serial bit carries the odd parity of the eight instruction bits.

At the clock edge that closes the spacer slot, the lower rank moves into the upper rank and the nine received bits are checked for odd parity. A word that fails the check is still loaded. The failure produces a one-clock error pulse and sets a sticky error flag. The flag stays set until software clears it through a clear input. The executing instruction is split into a 4-bit command field (upper half) and a 4-bit source, destination or mode field (lower half). Further decoding is done by the logic that uses these outputs.

Top module: `bsw_instr_stage`

## Requirements
- R1: While `rst` is sampled high, the block returns to this state on the next clock: `bit_pos` = 1, `exec_word` = 0, `par_err_pulse` = 0, `par_err_flag` = 0. The bits of a partly received word are discarded.
- R2: After reset, `bit_pos` steps 1, 2, …, 9 and then wraps to 1, advancing once per clock. `word_mark` is high only in the cycle where `bit_pos` is 9, so it goes high exactly once every nine clocks.
- R3: The serial bit sampled while `bit_pos` is k (k = 1..8) becomes bit k-1 of the instruction, so the word arrives least significant bit first. The bit sampled at position 9 is the parity bit and is not part of the instruction.
- R4: `exec_word` changes only on the clock edge that ends a cycle with `word_mark` high. After that edge it holds the eight bits received in the word that just ended, and it keeps that value through all nine positions of the following word.
- R5: `exec_cmd` equals bits 7..4 of `exec_word` and `exec_sel` equals bits 3..0.
- R6: A word passes the parity check when its nine bits, including the parity bit, contain an odd number of ones. A failing word drives `par_err_pulse` high for exactly one clock: the cycle after the spacer, while `bit_pos` is 1.
- R7: A failing word sets `par_err_flag`. The flag stays set until `err_clr` is sampled high at a clock edge where no failing word completes. If a failing word completes at the same edge as a clear request, the flag is set.
- R8: A word that fails the parity check is still loaded into `exec_word`.
- R9: A word that passes the parity check produces no pulse and does not change `par_err_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial instruction bit, LSB first, parity in the ninth slot |
| err_clr | input | 1 | Clears the sticky parity error flag |
| bit_pos | output | 4 | Current bit position, 1 to 9 |
| word_mark | output | 1 | High during the spacer slot (position 9) |
| exec_word | output | 8 | Upper rank: the instruction being executed |
| exec_cmd | output | 4 | Command field, bits 7..4 of the upper rank |
| exec_sel | output | 4 | Source, destination or mode field, bits 3..0 |
| par_err_pulse | output | 1 | One-clock pulse after a word that fails odd parity |
| par_err_flag | output | 1 | Sticky parity error indication |

## Verification
The hardest case to reach is a parity failure that completes at the same edge as a clear request. The failing word's check and the clear are sampled at a single edge, and that edge exists only once every nine clocks. The word-sending task lets the caller choose the parity bit and raise `err_clr` during the spacer position only, so the bench can place both events on that edge. A second hard case is a reset that arrives partway through a word while the error flag is set. The bench first leaves the flag set with a bad word, then aborts the next word after four bits, so that it can observe that the position count, the upper rank and the flag all restart.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

  typedef enum logic {
    PH_DATA   = 1'b0,
    PH_SPACER = 1'b1
  } bsw_phase_e;

  // Width needed to count positions 1..n inclusive
  function automatic int unsigned pos_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/bsw_word_timer.sv
module bsw_word_timer
  import bsw_pkg::*;
#(
  parameter int unsigned WORD_LEN = 9,
  parameter int unsigned POS_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [POS_W-1:0] pos,
  output bsw_phase_e       phase
);

  localparam logic [POS_W-1:0] POS_FIRST = POS_W'(1);
  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(WORD_LEN);

  function automatic logic [POS_W-1:0] step_pos(input logic [POS_W-1:0] p);
    return (p == POS_LAST) ? POS_FIRST : p + POS_W'(1);
  endfunction

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) pos_q <= POS_FIRST;
    else     pos_q <= step_pos(pos_q);
  end

  assign pos   = pos_q;
  assign phase = (pos_q == POS_LAST) ? PH_SPACER : PH_DATA;

endmodule

// File: rtl/bsw_lower_rank.sv
module bsw_lower_rank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned POS_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic [POS_W-1:0]  pos,
  output logic [DATA_W-1:0] word
);

  // One flop per instruction bit, each enabled at its own bit time
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    localparam logic [POS_W-1:0] MY_POS = POS_W'(g + 1);
    logic cell_q;
    always_ff @(posedge clk) begin
      if (rst)                cell_q <= 1'b0;
      else if (pos == MY_POS) cell_q <= ser_in;
    end
    assign word[g] = cell_q;
  end

endmodule

// File: rtl/bsw_parity_chk.sv
module bsw_parity_chk #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] word,
  input  logic              par_bit,
  input  logic              check_en,
  input  logic              err_clr,
  output logic              bad,
  output logic              err_pulse,
  output logic              err_flag
);

  // True when data plus parity bit hold an odd count of ones
  function automatic logic odd_ok(input logic [DATA_W-1:0] d, input logic p);
    return ^{d, p};
  endfunction

  logic pulse_q;
  logic flag_q;

  assign bad = check_en & ~odd_ok(word, par_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= bad;
      if (bad)          flag_q <= 1'b1;
      else if (err_clr) flag_q <= 1'b0;
    end
  end

  assign err_pulse = pulse_q;
  assign err_flag  = flag_q;

endmodule

// File: rtl/bsw_instr_stage.sv
module bsw_instr_stage
  import bsw_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned CMD_W  = DATA_W - SEL_W,
  parameter int unsigned POS_W  = pos_width(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              err_clr,
  output logic [POS_W-1:0]  bit_pos,
  output logic              word_mark,
  output logic [DATA_W-1:0] exec_word,
  output logic [CMD_W-1:0]  exec_cmd,
  output logic [SEL_W-1:0]  exec_sel,
  output logic              par_err_pulse,
  output logic              par_err_flag
);

  localparam int unsigned WORD_LEN = DATA_W + 1;

  bsw_phase_e        phase;
  logic [DATA_W-1:0] lower_word;
  logic [DATA_W-1:0] upper_q;
  logic              xfer_now;    // spacer slot: rank transfer at its closing edge
  logic              parity_bad;  // completed word fails odd parity

  bsw_word_timer #(
    .WORD_LEN (WORD_LEN),
    .POS_W    (POS_W)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .pos   (bit_pos),
    .phase (phase)
  );

  assign xfer_now  = (phase == PH_SPACER);
  assign word_mark = xfer_now;

  bsw_lower_rank #(
    .DATA_W (DATA_W),
    .POS_W  (POS_W)
  ) u_lower (
    .clk    (clk),
    .rst    (rst),
    .ser_in (ser_in),
    .pos    (bit_pos),
    .word   (lower_word)
  );

  bsw_parity_chk #(
    .DATA_W (DATA_W)
  ) u_par (
    .clk       (clk),
    .rst       (rst),
    .word      (lower_word),
    .par_bit   (ser_in),
    .check_en  (xfer_now),
    .err_clr   (err_clr),
    .bad       (parity_bad),
    .err_pulse (par_err_pulse),
    .err_flag  (par_err_flag)
  );

  always_ff @(posedge clk) begin
    if (rst)           upper_q <= '0;
    else if (xfer_now) upper_q <= lower_word;
  end

  assign exec_word = upper_q;
  assign exec_cmd  = upper_q[DATA_W-1 -: CMD_W];
  assign exec_sel  = upper_q[SEL_W-1:0];

endmodule

// File: rtl/bsw_instr_stage_chk.sv
module bsw_instr_stage_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned POS_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              err_clr,
  input logic [POS_W-1:0]  bit_pos,
  input logic              word_mark,
  input logic [DATA_W-1:0] exec_word,
  input logic              par_err_pulse,
  input logic              par_err_flag,
  input logic              xfer_now,
  input logic              parity_bad
);

  localparam logic [POS_W-1:0] LAST = POS_W'(DATA_W + 1);
  localparam logic [POS_W-1:0] ONE  = POS_W'(1);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (bit_pos == ONE && exec_word == '0 && !par_err_pulse && !par_err_flag));

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (bit_pos != LAST) |=> (bit_pos == $past(bit_pos) + ONE));

  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    word_mark |=> (bit_pos == ONE && !word_mark));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !xfer_now |=> $stable(exec_word));

  a_r6_pulse_follows: assert property (@(posedge clk) disable iff (rst)
    parity_bad |=> (par_err_pulse && par_err_flag));

  a_r6_pulse_single: assert property (@(posedge clk) disable iff (rst)
    par_err_pulse |=> !par_err_pulse);

  a_r6_only_at_spacer: assert property (@(posedge clk) disable iff (rst)
    parity_bad |-> word_mark);

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (par_err_flag && !err_clr) |=> par_err_flag);

  a_r9_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
    (!parity_bad && !par_err_flag) |=> !par_err_flag);

endmodule

bind bsw_instr_stage bsw_instr_stage_chk #(
  .DATA_W (DATA_W),
  .POS_W  (POS_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .err_clr       (err_clr),
  .bit_pos       (bit_pos),
  .word_mark     (word_mark),
  .exec_word     (exec_word),
  .par_err_pulse (par_err_pulse),
  .par_err_flag  (par_err_flag),
  .xfer_now      (xfer_now),
  .parity_bad    (parity_bad)
);

// File: tb/sim_bsw_instr_stage.sv
module sim_bsw_instr_stage;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_in = 1'b0;
  logic       err_clr = 1'b0;
  logic [3:0] bit_pos;
  logic       word_mark;
  logic [7:0] exec_word;
  logic [3:0] exec_cmd;
  logic [3:0] exec_sel;
  logic       par_err_pulse;
  logic       par_err_flag;

  int checks = 0;
  int fails  = 0;
  logic [7:0] cur_exec = 8'h00;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bsw_instr_stage u0 (
    .clk           (clk),
    .rst           (rst),
    .ser_in        (ser_in),
    .err_clr       (err_clr),
    .bit_pos       (bit_pos),
    .word_mark     (word_mark),
    .exec_word     (exec_word),
    .exec_cmd      (exec_cmd),
    .exec_sel      (exec_sel),
    .par_err_pulse (par_err_pulse),
    .par_err_flag  (par_err_flag)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Parity bit that makes the nine-bit total odd
  function automatic logic odd_bit(input logic [7:0] d);
    int ones = 0;
    for (int i = 0; i < 8; i++) if (d[i]) ones++;
    return (ones % 2 == 0) ? 1'b1 : 1'b0;
  endfunction

  // Sends one word; entered and left at a negedge with bit_pos = 1
  task automatic send_word(input logic [7:0] d, input bit bad, input bit clr_spacer);
    int tm_err = 0;
    int hold_err = 0;
    logic p;
    p = odd_bit(d) ^ bad;
    for (int i = 0; i < 9; i++) begin
      ser_in  = (i < 8) ? d[i] : p;
      err_clr = (i == 8) ? clr_spacer : 1'b0;
      if (bit_pos !== 4'(i + 1) || word_mark !== (i == 8)) tm_err++;
      if (exec_word !== cur_exec) hold_err++;
      @(negedge clk);
    end
    err_clr = 1'b0;
    check(tm_err == 0, "R2 position/marker sequence", tm_err, 0);
    check(hold_err == 0, "R4 upper rank held during word", hold_err, 0);
    cur_exec = d;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    cur_exec = 8'h00;
  endtask

  task automatic t_reset();
    do_reset();
    check(bit_pos == 4'd1, "R1 bit_pos after reset", bit_pos, 1);
    check(exec_word == 8'h00, "R1 exec_word after reset", exec_word, 0);
    check(!word_mark && !par_err_pulse && !par_err_flag, "R1 strobes and flags after reset",
          {word_mark, par_err_pulse, par_err_flag}, 0);
  endtask

  task automatic t_good_words();
    logic [7:0] pats [4] = '{8'hA5, 8'h3C, 8'h01, 8'h80};
    for (int k = 0; k < 4; k++) begin
      send_word(pats[k], 1'b0, 1'b0);
      check(exec_word == pats[k], "R3 R4 LSB-first load into upper rank", exec_word, pats[k]);
      check(exec_cmd == pats[k][7:4] && exec_sel == pats[k][3:0], "R5 field split",
            {exec_cmd, exec_sel}, pats[k]);
      check(!par_err_pulse && !par_err_flag, "R9 good word raises nothing",
            {par_err_pulse, par_err_flag}, 0);
    end
  endtask

  task automatic t_bad_word();
    send_word(8'h5A, 1'b1, 1'b0);
    check(exec_word == 8'h5A, "R8 failing word still loaded", exec_word, 8'h5A);
    check(par_err_pulse && bit_pos == 4'd1, "R6 pulse at position 1 after spacer",
          {par_err_pulse, bit_pos}, 5'h11);
    check(par_err_flag, "R7 flag set by failing word", par_err_flag, 1);
    @(negedge clk);
    check(!par_err_pulse, "R6 pulse lasts one clock", par_err_pulse, 0);
    check(par_err_flag, "R7 flag still set", par_err_flag, 1);
    // Finish the partly used word (position 2 now): resync by sending remaining 8 bits
    for (int i = 1; i < 9; i++) begin
      ser_in = 1'b0;
      if (i == 8) ser_in = 1'b1; // word 0x00 with odd parity bit
      @(negedge clk);
    end
    cur_exec = 8'h00;
    check(exec_word == 8'h00 && par_err_flag && !par_err_pulse, "R9 R7 good word keeps flag",
          {exec_word, par_err_flag, par_err_pulse}, 9'h002);
  endtask

  task automatic t_clear();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    check(!par_err_flag, "R7 err_clr clears flag", par_err_flag, 0);
    // Realign to position 1
    while (bit_pos != 4'd1) @(negedge clk);
    cur_exec = exec_word;
    send_word(8'hC3, 1'b0, 1'b0);
    check(!par_err_flag, "R9 flag stays clear on good word", par_err_flag, 0);
  endtask

  task automatic t_set_beats_clear();
    send_word(8'h7E, 1'b1, 1'b1);
    check(par_err_flag && par_err_pulse, "R7 set wins over simultaneous clear",
          {par_err_flag, par_err_pulse}, 2'b11);
  endtask

  task automatic t_mid_reset();
    // flag is set from previous test; abort a word after four bits
    for (int i = 0; i < 4; i++) begin
      ser_in = 1'b1;
      @(negedge clk);
    end
    do_reset();
    check(bit_pos == 4'd1 && exec_word == 8'h00 && !par_err_flag && !par_err_pulse,
          "R1 mid-word reset restarts", {bit_pos, exec_word, par_err_flag, par_err_pulse}, 14'h0400);
    send_word(8'h96, 1'b0, 1'b0);
    check(exec_word == 8'h96 && !par_err_flag, "R3 clean word after mid-word reset",
          {exec_word, par_err_flag}, {8'h96, 1'b0});
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_good_words();
    t_bad_word();
    t_clear();
    t_set_beats_clear();
    t_mid_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule